// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

The block is a countdown watchdog that escalates in two stages. When the counter runs out for the first time, the block sends a one-cycle system-management interrupt (SMI) pulse. Firmware can then service the event. If the counter runs out again before software kicks it, the block raises a reset request. That request stays high until the block itself is reset. After every expiry the counter reloads from a programmable register and keeps counting.

A no-reboot control bit can mask the reset stage. An external strap pin loads this bit at each rising edge of the power-good input. If the strap read high, the bit is forced to 1. Software writes can then never clear it until a later power-good edge samples the strap low. If the strap read low, software owns the bit and may set or clear it. A single write port serves both the control bit and the reload value; a select line picks which one is written.

Top module: `wdt_two_stage`

## Requirements
- R1: On a rising edge of `pwr_good_i` with `strap_i` high, the no-reboot bit becomes 1. Later second-stage expiries then raise no reset request.
- R2: While the last power-good edge sampled the strap low, a control write (`wr_sel_i` = 0) copies `wr_data_i[0]` into the no-reboot bit. Writing 1 sets the bit and writing 0 clears it.
- R3: While the last power-good edge sampled the strap high, a control write can set the no-reboot bit but can never clear it.
- R4: The counter expires when it is at zero and no kick is present. On an expiry with the stage flag clear, `smi_o` is high for exactly the one following cycle. This holds whatever the no-reboot bit is.
- R5: On an expiry with the stage flag already set and the no-reboot bit at 0, `reboot_req_o` rises in the following cycle.
- R6: With the no-reboot bit at 1, expiries after the first raise neither `reboot_req_o` nor `smi_o`, and the counter keeps running.
- R7: Each expiry loads the counter from the reload register, so the expiry period is reload+1 cycles. A reload write (`wr_sel_i` = 1) takes effect at the next load.
- R8: `kick_i` loads the counter from the reload register and clears the stage flag. A kick in the same cycle as a zero count suppresses that expiry.
- R9: Once `reboot_req_o` is high, it stays high until `rst_ni` is asserted.
- R10: The strap is sampled only on a power-good rising edge. A rising edge that samples the strap low unlocks the bit but leaves its value unchanged. If a write and a power-good edge arrive in the same cycle, the edge wins.
- R11: After reset, both outputs are low, the no-reboot bit is 0 and unlocked, and both the counter and the reload register hold `RELOAD_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Power-good level; its rising edge samples the strap |
| strap_i | input | 1 | No-reboot strap pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 no-reboot bit, 1 reload value |
| wr_data_i | input | CNT_W | Write data; bit 0 feeds the no-reboot bit |
| kick_i | input | 1 | Software kick |
| smi_o | output | 1 | One-cycle first-expiry interrupt pulse |
| reboot_req_o | output | 1 | Sticky reset request |

## Verification
The hardest case to reach is a locked no-reboot bit that software attempts to clear. It matters only at a second-stage expiry, and only reboot_req_o shows its effect.

The bench sweeps strap level, reload value and the kind of control write across full double-expiry windows. A reference model predicts both outputs on every cycle. Directed runs add:
- a kick on the zero count;
- reload writes in mid-count;
- power-good edges with the strap held both ways.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_RELOAD = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/wdt_strap_ctl.sv
module wdt_strap_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic strap_i,
  input  logic ctl_wr_i,
  input  logic wr_bit_i,
  output logic no_reboot_o
);
  logic pg_q, lock_q, nr_q;
  logic pg_rise;

  assign pg_rise = pwr_good_i & ~pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q   <= 1'b0;
      lock_q <= 1'b0;
      nr_q   <= 1'b0;
    end else begin
      pg_q <= pwr_good_i;
      if (pg_rise) begin
        lock_q <= strap_i;
        if (strap_i) nr_q <= 1'b1;
      end else if (ctl_wr_i) begin
        // locked bit can only be set further
        nr_q <= lock_q ? (nr_q | wr_bit_i) : wr_bit_i;
      end
    end
  end

  assign no_reboot_o = nr_q;

  // R1
  strap_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_rise && strap_i) |=> no_reboot_o);
  // R3
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && no_reboot_o) |=> no_reboot_o);
  // R10
  strap_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_rise && !ctl_wr_i) |=> $stable(no_reboot_o));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RELOAD_RST = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             kick_i,
  output logic             tmo_o
);
  localparam logic [CNT_W-1:0] RstVal = CNT_W'(RELOAD_RST);

  logic [CNT_W-1:0] cnt_q, reload_q;

  assign tmo_o = (cnt_q == '0) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= RstVal;
      reload_q <= RstVal;
    end else begin
      if (reload_wr_i) reload_q <= reload_val_i;
      if (kick_i || tmo_o) cnt_q <= reload_q;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  expiry_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> (cnt_q == $past(reload_q)));
  // R8
  kick_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_i,
  input  logic kick_i,
  input  logic no_reboot_i,
  output logic smi_o,
  output logic reboot_o
);
  logic stage_q, smi_q, reboot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= 1'b0;
      smi_q    <= 1'b0;
      reboot_q <= 1'b0;
    end else begin
      smi_q <= tmo_i && !stage_q;
      if (kick_i)     stage_q <= 1'b0;
      else if (tmo_i) stage_q <= 1'b1;
      if (tmo_i && stage_q && !no_reboot_i) reboot_q <= 1'b1;
    end
  end

  assign smi_o    = smi_q;
  assign reboot_o = reboot_q;

  // R4
  smi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> !smi_o);
  // R5
  second_reboot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && stage_q && !no_reboot_i) |=> reboot_o);
  // R6
  masked_reboot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_reboot_i && !reboot_o) |=> !reboot_o);
  // R9
  reboot_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |=> reboot_o);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RELOAD_RST = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             strap_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             kick_i,
  output logic             smi_o,
  output logic             reboot_req_o
);
  import wdt_pkg::*;

  wr_sel_e sel;
  logic ctl_wr, reload_wr, no_reboot, tmo;

  assign sel       = wr_sel_e'(wr_sel_i);
  assign ctl_wr    = wr_en_i && (sel == SEL_CTRL);
  assign reload_wr = wr_en_i && (sel == SEL_RELOAD);

  wdt_strap_ctl i_strap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .strap_i     (strap_i),
    .ctl_wr_i    (ctl_wr),
    .wr_bit_i    (wr_data_i[0]),
    .no_reboot_o (no_reboot)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reload_wr_i  (reload_wr),
    .reload_val_i (wr_data_i),
    .kick_i       (kick_i),
    .tmo_o        (tmo)
  );

  wdt_escalate i_escalate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmo_i       (tmo),
    .kick_i      (kick_i),
    .no_reboot_i (no_reboot),
    .smi_o       (smi_o),
    .reboot_o    (reboot_req_o)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!smi_o && !reboot_req_o));
endmodule

// File: tb/test_wdt_two_stage.sv
`timescale 1ns/1ps
module test_wdt_two_stage;
  localparam int CW = 4;
  localparam int RR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, strap = 1'b0, we = 1'b0, sel = 1'b0, kick = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic smi, rb;

  int vecs = 0, fails = 0;

  // reference model state
  logic m_pg, m_lock, m_nr, m_first, m_smi, m_rb;
  logic [CW-1:0] m_cnt, m_rel;

  always #4 clk = ~clk;

  wdt_two_stage #(.CNT_W(CW), .RELOAD_RST(RR)) i_wdt_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .strap_i(strap),
    .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wdata), .kick_i(kick),
    .smi_o(smi), .reboot_req_o(rb)
  );

  task automatic model_reset();
    m_pg = 0; m_lock = 0; m_nr = 0; m_first = 0; m_smi = 0; m_rb = 0;
    m_cnt = CW'(RR); m_rel = CW'(RR);
  endtask

  task automatic check(string tag);
    vecs++;
    if (smi !== m_smi) begin
      fails++;
      $display("FAIL %s smi_o actual %b expected %b", tag, smi, m_smi);
    end
    vecs++;
    if (rb !== m_rb) begin
      fails++;
      $display("FAIL %s reboot_req_o actual %b expected %b", tag, rb, m_rb);
    end
  endtask

  task automatic step(logic p, logic s, logic w, logic sl, logic [CW-1:0] d,
                      logic k, string tag);
    logic rise, tmo;
    pg = p; strap = s; we = w; sel = sl; wdata = d; kick = k;
    @(posedge clk);
    rise = p && !m_pg;
    tmo  = (m_cnt == 0) && !k;
    m_smi = tmo && !m_first;
    m_rb  = m_rb | (tmo && m_first && !m_nr);
    m_first = k ? 1'b0 : (tmo ? 1'b1 : m_first);
    m_cnt = (k || tmo) ? m_rel : m_cnt - 1'b1;
    if (rise) begin
      if (s) m_nr = 1'b1;
      m_lock = s;
    end else if (w && !sl) begin
      m_nr = m_lock ? (m_nr | d[0]) : d[0];
    end
    if (w && sl) m_rel = d;
    m_pg = p;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(pg, strap, 1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pg = 0; strap = 0; we = 0; sel = 0; wdata = '0; kick = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R11");
    idle(5, "R11");                  // no expiry before RELOAD_RST+1 cycles
    idle(2 * (RR + 1), "R5");        // first SMI then reboot, strap absent

    // sweep strap level x reload value x control write
    for (int st = 0; st < 2; st++)
      for (int rl = 0; rl < 7; rl++)
        for (int wk = 0; wk < 3; wk++) begin
          do_reset();
          step(1'b1, st[0], 1'b1, 1'b1, CW'(rl), 1'b0, "R7");
          step(1'b1, 1'b0, 1'b1, 1'b1, CW'(rl), 1'b1, "R8");
          if (wk != 0)
            step(1'b1, 1'b0, 1'b1, 1'b0, CW'(wk == 1), 1'b0, st ? "R3" : "R2");
          idle(3 * (rl + 1) + 3, st ? "R6" : "R5");
        end

    // R1: strap high, no writes, reboot masked
    do_reset();
    step(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R1");
    idle(4 * (RR + 1), "R1");

    // R3: clear attempts under lock
    do_reset();
    step(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R3");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R3");
    idle(3 * (RR + 1), "R3");

    // R10: strap toggles without edge; edge with strap low unlocks but keeps bit
    do_reset();
    step(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R10");
    for (int i = 0; i < 4; i++) step(1'b1, i[0], 1'b0, 1'b0, '0, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R10");   // edge beats write
    idle(3 * (RR + 1), "R10");
    step(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b1, "R2");    // now clear is allowed
    idle(3 * (RR + 1), "R2");

    // R8: kicks land on the zero count; escalation restarts
    do_reset();
    step(1'b1, 1'b0, 1'b1, 1'b1, CW'(3), 1'b1, "R8");
    for (int r = 0; r < 5; r++) begin
      idle(3, "R8");
      step(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R8");
    end
    idle(5, "R8");                   // one expiry -> SMI
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R8");
    idle(5, "R4");                   // SMI again after kick cleared stage

    // R7: reload changes mid-count
    do_reset();
    idle(2, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b1, CW'(1), 1'b0, "R7");
    idle(6, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, CW'(1), 1'b0, "R6");
    idle(10, "R6");

    // R9: reboot held; kicks do not drop it
    do_reset();
    idle(2 * (RR + 1) + 1, "R9");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, i[0], "R9");
    idle(3 * (RR + 1), "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule